// File: doc/BRIEF.md
# Segment Selector Translation Unit

This block converts a logical address, a 16-bit selector held in one of six segment slots plus a 32-bit offset, into a 32-bit linear address. Each slot keeps the selector's descriptor fields (base and limit) in a hidden cache. The cache is refilled only when software loads a new selector into that slot. When a selector is loaded, the unit picks the global or the local table base from the selector's table bit and adds eight times the selector index. It then reads the 8-byte descriptor as two 32-bit words over a simple valid/ready read port.

Once a slot is filled, each translation request needs one compare and one add. It makes no memory access. The result appears one cycle after the request is accepted. It is either a linear address or a protection fault. A fault is raised when the offset exceeds the cached limit, when the slot holds a null selector, or when the slot number does not exist. A request aimed at a slot whose descriptor is still being fetched is held off with a stall signal. Requests to the other slots proceed.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, every slot is null, `ldReady` is 1, `rdValid` is 0, and a translation through any slot returns a fault and no linear address.
- R2: The descriptor address is the selected table base plus `ldSel[15:3]` times 8, computed modulo 2^32. The table is picked by `ldSel[2]`: 0 selects `gtBase` and 1 selects `ltBase`. `ldSel[1:0]` is ignored. The low word is read at that address and the high word at that address plus 4.
- R3: A selector load is accepted when `ldValid` and `ldReady` are both high. Each descriptor word is taken in the cycle where `rdValid` and `rdReady` are both high. While a word is awaited, `rdValid` and `rdAddr` hold their values. `ldReady` stays low until the high word has been taken.
- R4: With low word L and high word H, the cached base is {H[31:24], H[7:0], L[31:16]} and the cached 20-bit limit is {H[19:16], L[15:0]}.
- R5: An accepted translation with no fault gives `linValid`=1 and `linAddr` = base + `xOffset` modulo 2^32, one cycle after acceptance.
- R6: An offset greater than the zero-extended limit gives `faultOut`=1 and `linValid`=0 one cycle after acceptance. An offset equal to the limit translates normally.
- R7: A selector with index 0 and `ldSel[2]`=0 marks the slot null without any memory read. Later accesses through that slot fault. Index 0 with `ldSel[2]`=1 is fetched like any other selector.
- R8: `xStall` is high while `xValid` targets the slot whose descriptor is being fetched. A stalled request produces no result. Requests to other slots are accepted during the fetch.
- R9: Translations never start a memory read. A slot keeps its cached descriptor until that same slot is loaded again.
- R10: A translation naming slot 6 or 7 faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| gtBase | input | 32 | Global descriptor table base |
| ltBase | input | 32 | Local descriptor table base |
| ldValid | input | 1 | Selector load request |
| ldSeg | input | 3 | Slot to load |
| ldSel | input | 16 | Selector value |
| ldReady | output | 1 | Load can be accepted |
| rdValid | output | 1 | Descriptor read request |
| rdAddr | output | 32 | Descriptor word address |
| rdReady | input | 1 | Read word delivered this cycle |
| rdData | input | 32 | Read word |
| xValid | input | 1 | Translation request |
| xSeg | input | 3 | Slot used for translation |
| xOffset | input | 32 | Logical offset |
| xStall | output | 1 | Request held off by a fetch on its slot |
| linValid | output | 1 | Linear address valid |
| linAddr | output | 32 | Linear address |
| faultOut | output | 1 | Protection fault for the accepted request |

## Verification
The bench builds the block with its default of six slots. With that setting, every slot is loaded from both tables and with several indices, and the slot numbers 6 and 7 of the 3-bit slot field can be used to reach the nonexistent-slot case. The memory model returns words derived arithmetically from the address, so every base and limit combination is predictable. Each load is followed by offsets at zero, at the limit, one past the limit and at the maximum, which covers the limit boundary and wraparound. Read latencies of zero to two cycles bring the handshake hold and the stall window within reach.

// File: rtl/segx_pkg.sv
package segx_pkg;
  localparam int ADDR_W = 32;
  localparam int SEL_W  = 16;
  localparam int LIM_W  = 20;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} fetchSt_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capLoad;  // latch slot number and descriptor address
    logic setNull;  // mark the loaded slot null
    logic takeLow;  // store the low descriptor word
    logic hiWord;   // address the high word
    logic commit;   // write base/limit into the slot cache
  } segStrobe_t;
endpackage

// File: rtl/segx_ctrl.sv
module segx_ctrl
  import segx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ldValid,
  input  logic       ldIsNull,
  input  logic       rdReady,
  output logic       ldReady,
  output logic       rdValid,
  output segStrobe_t stb
);
  fetchSt_t st, stNext;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stb    = '0;
    stNext = st;
    unique case (st)
      ST_IDLE: if (ldValid) begin
        if (ldIsNull) stb.setNull = 1'b1;
        else begin
          stb.capLoad = 1'b1;
          stNext      = ST_LOW;
        end
      end
      ST_LOW: if (rdReady) begin
        stb.takeLow = 1'b1;
        stNext      = ST_HIGH;
      end
      ST_HIGH: begin
        stb.hiWord = 1'b1;
        if (rdReady) begin
          stb.commit = 1'b1;
          stNext     = ST_IDLE;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  assign ldReady = (st == ST_IDLE);
  assign rdValid = (st != ST_IDLE);
endmodule

// File: rtl/segx_dp.sv
module segx_dp
  import segx_pkg::*;
#(
  parameter int SEG_N = 6,
  parameter int SIW   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  segStrobe_t        stb,
  input  logic              busy,
  input  logic [ADDR_W-1:0] gtBase,
  input  logic [ADDR_W-1:0] ltBase,
  input  logic [SIW-1:0]    ldSeg,
  input  logic [SEL_W-1:0]  ldSel,
  input  logic [WORD_W-1:0] rdData,
  input  logic              xValid,
  input  logic [SIW-1:0]    xSeg,
  input  logic [ADDR_W-1:0] xOffset,
  output logic              ldIsNull,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              xStall,
  output logic              linValid,
  output logic [ADDR_W-1:0] linAddr,
  output logic              faultOut
);
  logic [SIW-1:0]    pendSeg;
  logic [ADDR_W-1:0] descAddr;
  logic [WORD_W-1:0] lowWord;
  logic [ADDR_W-1:0] segBase [SEG_N];
  logic [LIM_W-1:0]  segLim  [SEG_N];
  logic [SEG_N-1:0]  segOk;

  assign ldIsNull = (ldSel[SEL_W-1:3] == '0) && !ldSel[2];
  assign rdAddr   = stb.hiWord ? descAddr + ADDR_W'(4) : descAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendSeg  <= '0;
      descAddr <= '0;
      lowWord  <= '0;
    end else begin
      if (stb.capLoad) begin
        pendSeg  <= ldSeg;
        descAddr <= (ldSel[2] ? ltBase : gtBase)
                    + ADDR_W'({ldSel[SEL_W-1:3], 3'b000});
      end
      if (stb.takeLow) lowWord <= rdData;
    end
  end

  // one cache slot per segment register
  for (genvar g = 0; g < SEG_N; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        segOk[g]   <= 1'b0;
        segBase[g] <= '0;
        segLim[g]  <= '0;
      end else if (stb.setNull && ldSeg == SIW'(g)) begin
        segOk[g] <= 1'b0;
      end else if (stb.commit && pendSeg == SIW'(g)) begin
        segOk[g]   <= 1'b1;
        segBase[g] <= {rdData[31:24], rdData[7:0], lowWord[31:16]};
        segLim[g]  <= {rdData[19:16], lowWord[15:0]};
      end
    end
  end

  logic              accept, hitOk;
  logic [ADDR_W-1:0] selBase;
  logic [LIM_W-1:0]  selLim;
  logic              selOk;

  assign xStall = xValid && busy && (xSeg == pendSeg);
  assign accept = xValid && !xStall;

  always_comb begin
    selBase = '0;
    selLim  = '0;
    selOk   = 1'b0;
    for (int i = 0; i < SEG_N; i++) begin
      if (xSeg == SIW'(i)) begin
        selBase = segBase[i];
        selLim  = segLim[i];
        selOk   = segOk[i];
      end
    end
  end

  assign hitOk = selOk && (xOffset <= ADDR_W'(selLim));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linValid <= 1'b0;
      faultOut <= 1'b0;
      linAddr  <= '0;
    end else begin
      linValid <= accept && hitOk;
      faultOut <= accept && !hitOk;
      linAddr  <= (accept && hitOk) ? selBase + xOffset : '0;
    end
  end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import segx_pkg::*;
#(
  parameter int SEG_N = 6,
  localparam int SIW  = (SEG_N > 1) ? $clog2(SEG_N) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] gtBase,
  input  logic [ADDR_W-1:0] ltBase,
  input  logic              ldValid,
  input  logic [SIW-1:0]    ldSeg,
  input  logic [SEL_W-1:0]  ldSel,
  output logic              ldReady,
  output logic              rdValid,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdReady,
  input  logic [WORD_W-1:0] rdData,
  input  logic              xValid,
  input  logic [SIW-1:0]    xSeg,
  input  logic [ADDR_W-1:0] xOffset,
  output logic              xStall,
  output logic              linValid,
  output logic [ADDR_W-1:0] linAddr,
  output logic              faultOut
);
  segStrobe_t stb;
  logic       ldIsNull;

  segx_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .ldValid(ldValid), .ldIsNull(ldIsNull),
    .rdReady(rdReady), .ldReady(ldReady), .rdValid(rdValid), .stb(stb)
  );

  segx_dp #(.SEG_N(SEG_N), .SIW(SIW)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(rdValid),
    .gtBase(gtBase), .ltBase(ltBase), .ldSeg(ldSeg), .ldSel(ldSel),
    .rdData(rdData), .xValid(xValid), .xSeg(xSeg), .xOffset(xOffset),
    .ldIsNull(ldIsNull), .rdAddr(rdAddr), .xStall(xStall),
    .linValid(linValid), .linAddr(linAddr), .faultOut(faultOut)
  );
endmodule

// File: rtl/segx_chk.sv
module segx_chk (
  input logic        clk,
  input logic        rstN,
  input logic        ldValid,
  input logic        ldReady,
  input logic [15:0] ldSel,
  input logic        rdValid,
  input logic        rdReady,
  input logic [31:0] rdAddr,
  input logic        xValid,
  input logic        xStall,
  input logic        linValid,
  input logic        faultOut
);
  // R5 R6
  one_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(linValid && faultOut));

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && !rdReady |=> rdValid && $stable(rdAddr));

  // R3
  ld_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !ldReady);

  // R8
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    xValid && xStall |=> !linValid && !faultOut);

  // R7
  null_nofetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldValid && ldReady && ldSel[15:3] == 13'd0 && !ldSel[2] |=> !rdValid);
endmodule

bind seg_xlate_unit segx_chk uChk (
  .clk(clk), .rstN(rstN), .ldValid(ldValid), .ldReady(ldReady),
  .ldSel(ldSel), .rdValid(rdValid), .rdReady(rdReady), .rdAddr(rdAddr),
  .xValid(xValid), .xStall(xStall), .linValid(linValid),
  .faultOut(faultOut)
);

// File: tb/sim_seg_xlate_unit.sv
module sim_seg_xlate_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] gtBase = 32'h0001_2340;
  logic [31:0] ltBase = 32'hFFFF_F100;
  logic        ldValid = 1'b0;
  logic [2:0]  ldSeg = '0;
  logic [15:0] ldSel = '0;
  logic        ldReady, rdValid;
  logic [31:0] rdAddr;
  logic        rdReady = 1'b0;
  logic [31:0] rdData = '0;
  logic        xValid = 1'b0;
  logic [2:0]  xSeg = '0;
  logic [31:0] xOffset = '0;
  logic        xStall, linValid, faultOut;
  logic [31:0] linAddr;

  int checkCount = 0;
  int failCount  = 0;

  logic [31:0] expBase [8];
  logic [19:0] expLim  [8];
  logic        expOk   [8];

  always #5 clk = ~clk;

  seg_xlate_unit u0 (
    .clk(clk), .rstN(rstN), .gtBase(gtBase), .ltBase(ltBase),
    .ldValid(ldValid), .ldSeg(ldSeg), .ldSel(ldSel), .ldReady(ldReady),
    .rdValid(rdValid), .rdAddr(rdAddr), .rdReady(rdReady), .rdData(rdData),
    .xValid(xValid), .xSeg(xSeg), .xOffset(xOffset), .xStall(xStall),
    .linValid(linValid), .linAddr(linAddr), .faultOut(faultOut)
  );

  function automatic logic [31:0] memWord(logic [31:0] a);
    return (a * 32'h2545_F491) ^ 32'hC3A5_1E7B;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic serveWord(logic [31:0] a, int dly);
    for (int i = 0; i < dly; i++) begin
      chk(rdValid && rdAddr == a, "R3 hold/R2 addr", rdAddr, a);
      chk(!ldReady, "R3 ldReady low", 32'(ldReady), 32'd0);
      @(negedge clk);
    end
    chk(rdValid && rdAddr == a, "R2 addr", rdAddr, a);
    rdReady = 1'b1;
    rdData  = memWord(a);
    @(posedge clk);
    #1 rdReady = 1'b0;
    @(negedge clk);
  endtask

  task automatic beginLoad(int seg, logic [15:0] sel);
    ldValid = 1'b1; ldSeg = 3'(seg); ldSel = sel;
    #1 chk(ldReady, "R3 ldReady", 32'(ldReady), 32'd1);
    @(posedge clk);
    #1 ldValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic finishLoad(int seg, logic [15:0] sel, int dly);
    logic [31:0] a, lo, hi;
    if (sel[15:3] == 13'd0 && !sel[2]) begin
      chk(!rdValid, "R7 no fetch", 32'(rdValid), 32'd0);
      expOk[seg] = 1'b0;
      return;
    end
    a = (sel[2] ? ltBase : gtBase) + {16'd0, sel[15:3], 3'b000};
    serveWord(a, dly);
    serveWord(a + 32'd4, dly);
    lo = memWord(a); hi = memWord(a + 32'd4);
    expBase[seg] = {hi[31:24], hi[7:0], lo[31:16]};
    expLim[seg]  = {hi[19:16], lo[15:0]};
    expOk[seg]   = 1'b1;
    chk(ldReady && !rdValid, "R3 fetch done", 32'(ldReady), 32'd1);
  endtask

  task automatic loadSeg(int seg, logic [15:0] sel, int dly);
    beginLoad(seg, sel);
    finishLoad(seg, sel, dly);
  endtask

  task automatic xlate(int seg, logic [31:0] off, string req);
    bit expF;
    xValid = 1'b1; xSeg = 3'(seg); xOffset = off;
    #1 chk(!xStall, "R8 no stall", 32'(xStall), 32'd0);
    @(posedge clk);
    #1 xValid = 1'b0;
    @(negedge clk);
    expF = (seg >= 6) || !expOk[seg] || (off > {12'd0, expLim[seg]});
    chk(faultOut == expF, req, 32'(faultOut), 32'(expF));
    chk(linValid == !expF, req, 32'(linValid), 32'(!expF));
    if (!expF) chk(linAddr == expBase[seg] + off, req, linAddr, expBase[seg] + off);
    chk(!rdValid, "R9 no read", 32'(rdValid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCount++; checkCount++;
    $display("FAIL R3 watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      expOk[i] = 1'b0; expBase[i] = '0; expLim[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ldReady && !rdValid && !linValid && !faultOut, "R1 reset",
        {ldReady, rdValid, linValid, faultOut}, 32'b1000);
    for (int s = 0; s < 6; s++) xlate(s, 32'd0, "R1 null after reset");

    // sweep: every slot, both tables, several indices
    for (int s = 0; s < 6; s++)
      for (int t = 0; t < 2; t++)
        for (int k = 0; k < 3; k++) begin
          logic [12:0] idx;
          logic [15:0] sel;
          idx = 13'(s * 37 + k * 501 + t * 3 + 1);
          sel = {idx, 1'(t), 2'(k)};
          loadSeg(s, sel, (s + k) % 3);
          xlate(s, 32'd0, "R4 base");
          xlate(s, {12'd0, expLim[s]}, "R6 at limit");
          xlate(s, {12'd0, expLim[s]} + 32'd1, "R6 past limit");
          xlate(s, {13'd0, expLim[s][19:1]}, "R5 mid");
          xlate(s, 32'hFFFF_FFFF, "R6 max offset");
        end

    // R9: all caches still hold their last descriptor
    for (int s = 0; s < 6; s++) xlate(s, {12'd0, expLim[s]}, "R9 retained");

    // R10: nonexistent slots
    xlate(6, 32'd0, "R10 slot6");
    xlate(7, 32'd0, "R10 slot7");

    // R7: null selector, rpl bits ignored; index 0 in local table fetched
    loadSeg(3, 16'h0003, 0);
    xlate(3, 32'd0, "R7 null fault");
    xlate(2, 32'd0, "R9 other slot kept");
    loadSeg(3, 16'h0004, 1);
    xlate(3, 32'd0, "R7 local idx0 ok");

    // R2: table base wraps modulo 2^32
    loadSeg(4, 16'hFFFC, 2);
    xlate(4, {12'd0, expLim[4]}, "R2 wrapped addr");

    // R8: stall on fetching slot, other slot runs
    beginLoad(2, 16'h0A51);
    xValid = 1'b1; xSeg = 3'd2; xOffset = 32'd0;
    #1 chk(xStall, "R8 stall", 32'(xStall), 32'd1);
    @(posedge clk);
    #1 xSeg = 3'd1;
    @(negedge clk);
    chk(!linValid && !faultOut, "R8 stalled no result",
        {linValid, faultOut}, 32'd0);
    chk(!xStall, "R8 other slot", 32'(xStall), 32'd0);
    @(posedge clk);
    #1 xValid = 1'b0;
    @(negedge clk);
    chk(linValid && linAddr == expBase[1], "R8 other result", linAddr, expBase[1]);
    finishLoad(2, 16'h0A51, 1);
    xlate(2, 32'd5, "R8 after fetch");

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule